// File: doc/BRIEF.md
# Dual-Path Latch/Register Bus Transceiver

This block moves an 18-bit word between two buses, called A and B, in either direction. Each direction has its own storage stage. A mode input picks how that stage works. With the mode input high, the stage is a transparent latch and the far-side output follows the near-side input in the same cycle. With the mode input low, the stage keeps its contents. It loads a new word only on a falling transition of that direction's capture clock. Each direction also has its own output enable, and the two enables have opposite polarity. The A-to-B enable is active high and the B-to-A enable is active low.

The buses are not modelled as inout nets. Each output is a data vector plus an enable flag, so the high-impedance state can be checked directly. Each input also has a per-bit "driven" mask. An optional keeper holds a bit at its last driven level while nothing drives it. The whole block runs on one system clock, `clk`. The capture clocks and mode inputs are sampled as levels on that clock. A falling capture clock is seen when the clock was high at one `clk` edge and is low in the current cycle.

Top module: `dual_path_xcvr`

## Requirements
- R1: During and right after reset, both storage stages hold zero. With the mode input low, `b_out` and `a_out` read 0.
- R2: While `le_ab` is 1, `b_out` equals the effective A input in the same cycle, bit for bit (non-inverting).
- R3: While `le_ab` is 0 and no falling edge of `cp_ab` is seen, `b_out` keeps its previous value whatever A does.
- R4: If `le_ab` is 0 and `cp_ab` was 1 at the last `clk` edge and is 0 now, the effective A word is stored at the next `clk` edge. It shows on `b_out` from the following cycle.
- R5: When `le_ab` goes from 1 to 0, the stage keeps the A word it loaded at the last `clk` edge where `le_ab` was 1, with no capture clock needed.
- R6: A rising edge of `cp_ab` loads nothing. A falling edge while `le_ab` is 1 changes nothing beyond the transparent behaviour.
- R7: `b_out_en` is 1 exactly when `oe_ab` is 1 (active high). When it is 0, B is high-impedance.
- R8: `a_out_en` is 1 exactly when `oe_ba_n` is 0 (active low). When it is 1, A is high-impedance.
- R9: The B-to-A path behaves like R2 to R6, using `b_in`, `le_ba` and `cp_ba`, and drives `a_out`.
- R10: With the keeper enabled, an input bit whose `*_drv` bit is 0 takes the effective value that bit had at the previous `clk` edge. A bit whose `*_drv` bit is 1 takes the input value.
- R11: `b_out` and `a_out` carry the stored or transparent word whatever the state of their enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 18 | Value present on the A bus |
| a_drv | input | 18 | Per-bit flag: 1 = A bit driven externally |
| b_in | input | 18 | Value present on the B bus |
| b_drv | input | 18 | Per-bit flag: 1 = B bit driven externally |
| le_ab | input | 1 | A-to-B mode: 1 transparent, 0 hold/capture |
| cp_ab | input | 1 | A-to-B capture clock, active on its falling edge |
| oe_ab | input | 1 | A-to-B output enable, active high |
| le_ba | input | 1 | B-to-A mode: 1 transparent, 0 hold/capture |
| cp_ba | input | 1 | B-to-A capture clock, active on its falling edge |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Word presented toward the B bus |
| b_out_en | output | 1 | 1 = B bus driven, 0 = high-impedance |
| a_out | output | 18 | Word presented toward the A bus |
| a_out_en | output | 1 | 1 = A bus driven, 0 = high-impedance |

## Verification
Directed sequences cover each mode on its own:
- Holding the mode input high tells transparent pass-through apart from stored data.
- Dropping the mode input with no capture clock shows retention.
- A rising then falling capture clock separates the capturing edge from the inert one.
- A falling clock while transparent shows that it adds nothing.

Keeper sequences release the drive mask after a known word and then change the raw input. The output must show the held word, not the raw one.

A long random run then mixes modes, clock toggles, partial drive masks and enables in both directions. Every cycle is compared against a bench model. This exposes ordering faults, such as capture on the wrong edge or loss of the last transparent word, that directed cases could miss.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int unsigned XCVR_WIDTH = 18;

  // Falling transition seen between last sample and now.
  function automatic logic fall_seen(input logic prev_lvl, input logic now_lvl);
    return prev_lvl & ~now_lvl;
  endfunction

  // Storage loads while transparent, or on a falling capture clock.
  function automatic logic load_now(input logic transparent, input logic fall);
    return transparent | fall;
  endfunction

  // Keeper: driven bit passes, undriven bit keeps its last level.
  function automatic logic keep_bit(input logic drv, input logic raw, input logic held);
    return drv ? raw : held;
  endfunction

endpackage

// File: rtl/bus_keeper.sv
module bus_keeper #(
  parameter int unsigned WIDTH   = xcvr_pkg::XCVR_WIDTH,
  parameter bit          HOLD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] bus_in,
  input  logic [WIDTH-1:0] bus_drv,
  output logic [WIDTH-1:0] bus_eff
);
  import xcvr_pkg::*;

  generate
    if (HOLD_EN) begin : g_hold
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic held_q;
        assign bus_eff[i] = keep_bit(bus_drv[i], bus_in[i], held_q);
        always_ff @(posedge clk) begin
          if (!rst_n) held_q <= 1'b0;
          else        held_q <= bus_eff[i];
        end
      end
    end else begin : g_pass
      assign bus_eff = bus_in;
    end
  endgenerate

endmodule

// File: rtl/fall_detect.sv
module fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fall
);
  import xcvr_pkg::*;

  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign fall = fall_seen(prev_q, level);

endmodule

// File: rtl/xcvr_stage.sv
module xcvr_stage #(
  parameter int unsigned WIDTH = xcvr_pkg::XCVR_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             le,
  input  logic             cp,
  input  logic             oe_act,
  output logic [WIDTH-1:0] dout,
  output logic             dout_en,
  output logic             cap_fall
);
  import xcvr_pkg::*;

  logic [WIDTH-1:0] store_q;
  logic             load;

  fall_detect u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .level (cp),
    .fall  (cap_fall)
  );

  assign load = load_now(le, cap_fall);

  always_ff @(posedge clk) begin
    if (!rst_n)    store_q <= '0;
    else if (load) store_q <= din;
  end

  assign dout    = le ? din : store_q;
  assign dout_en = oe_act;

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int unsigned WIDTH   = xcvr_pkg::XCVR_WIDTH,
  parameter bit          HOLD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] a_drv,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] b_drv,
  input  logic             le_ab,
  input  logic             cp_ab,
  input  logic             oe_ab,
  input  logic             le_ba,
  input  logic             cp_ba,
  input  logic             oe_ba_n,
  output logic [WIDTH-1:0] b_out,
  output logic             b_out_en,
  output logic [WIDTH-1:0] a_out,
  output logic             a_out_en
);

  // Named internal events, visible to the bound checker.
  logic [WIDTH-1:0] a_eff;
  logic [WIDTH-1:0] b_eff;
  logic             ab_fall;
  logic             ba_fall;

  bus_keeper #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) u_keep_a (
    .clk (clk), .rst_n (rst_n), .bus_in (a_in), .bus_drv (a_drv), .bus_eff (a_eff)
  );

  bus_keeper #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) u_keep_b (
    .clk (clk), .rst_n (rst_n), .bus_in (b_in), .bus_drv (b_drv), .bus_eff (b_eff)
  );

  xcvr_stage #(.WIDTH(WIDTH)) u_ab (
    .clk (clk), .rst_n (rst_n), .din (a_eff), .le (le_ab), .cp (cp_ab),
    .oe_act (oe_ab), .dout (b_out), .dout_en (b_out_en), .cap_fall (ab_fall)
  );

  xcvr_stage #(.WIDTH(WIDTH)) u_ba (
    .clk (clk), .rst_n (rst_n), .din (b_eff), .le (le_ba), .cp (cp_ba),
    .oe_act (~oe_ba_n), .dout (a_out), .dout_en (a_out_en), .cap_fall (ba_fall)
  );

endmodule

// File: rtl/dual_path_xcvr_chk.sv
module dual_path_xcvr_chk #(
  parameter int unsigned WIDTH   = 18,
  parameter bit          HOLD_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_eff,
  input logic [WIDTH-1:0] b_eff,
  input logic [WIDTH-1:0] a_drv,
  input logic             le_ab,
  input logic             le_ba,
  input logic             ab_fall,
  input logic             ba_fall,
  input logic             oe_ab,
  input logic             oe_ba_n,
  input logic [WIDTH-1:0] b_out,
  input logic [WIDTH-1:0] a_out,
  input logic             b_out_en,
  input logic             a_out_en
);

  assert_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    le_ab |-> (b_out == a_eff));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && $past(!le_ab) && !$past(ab_fall)) |-> $stable(b_out));

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!le_ab && ab_fall) && !le_ab) |-> (b_out == $past(a_eff)));

  assert_retain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(le_ab) && !le_ab) |-> (b_out == $past(a_eff)));

  assert_oe_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b_out_en == oe_ab);

  assert_oe_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    a_out_en == !oe_ba_n);

  assert_ba_transparent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    le_ba |-> (a_out == b_eff));

  assert_ba_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!le_ba && ba_fall) && !le_ba) |-> (a_out == $past(b_eff)));

  generate
    if (HOLD_EN) begin : g_keep_chk
      assert_keeper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_drv == '0) && $past(a_drv == '0)) |-> $stable(a_eff));
    end
  endgenerate

endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) chk_i (
  .clk (clk), .rst_n (rst_n), .a_eff (a_eff), .b_eff (b_eff), .a_drv (a_drv),
  .le_ab (le_ab), .le_ba (le_ba), .ab_fall (ab_fall), .ba_fall (ba_fall),
  .oe_ab (oe_ab), .oe_ba_n (oe_ba_n), .b_out (b_out), .a_out (a_out),
  .b_out_en (b_out_en), .a_out_en (a_out_en)
);

// File: tb/dual_path_xcvr_tb_top.sv
module dual_path_xcvr_tb_top;
  localparam int unsigned W          = 18;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned RAND_CYC   = 3000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, a_drv, b_in, b_drv;
  logic         le_ab, cp_ab, oe_ab, le_ba, cp_ba, oe_ba_n;
  logic [W-1:0] b_out, a_out;
  logic         b_out_en, a_out_en;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;

  // Bench model state
  logic [W-1:0] m_hold_a, m_hold_b, m_st_ab, m_st_ba;
  logic         m_cp_ab, m_cp_ba;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_path_xcvr dut_i (
    .clk (clk), .rst_n (rst_n), .a_in (a_in), .a_drv (a_drv), .b_in (b_in),
    .b_drv (b_drv), .le_ab (le_ab), .cp_ab (cp_ab), .oe_ab (oe_ab),
    .le_ba (le_ba), .cp_ba (cp_ba), .oe_ba_n (oe_ba_n), .b_out (b_out),
    .b_out_en (b_out_en), .a_out (a_out), .a_out_en (a_out_en)
  );

  // Effective input: per bit, either the raw value or the kept one.
  function automatic logic [W-1:0] eff_word(logic [W-1:0] raw, logic [W-1:0] drv,
                                           logic [W-1:0] held);
    return (raw & drv) | (held & ~drv);
  endfunction

  function automatic logic [W-1:0] view(logic le, logic [W-1:0] eff, logic [W-1:0] st);
    if (le) return eff;
    return st;
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: inputs already set after negedge; check, then advance model at posedge.
  task automatic cycle(string tag);
    logic [W-1:0] ea, eb;
    #1;
    ea = eff_word(a_in, a_drv, m_hold_a);
    eb = eff_word(b_in, b_drv, m_hold_b);
    check(tag, "b_out", b_out, view(le_ab, ea, m_st_ab));
    check(tag, "a_out", a_out, view(le_ba, eb, m_st_ba));
    check(tag, "b_out_en", {{(W-1){1'b0}}, b_out_en}, {{(W-1){1'b0}}, oe_ab});
    check(tag, "a_out_en", {{(W-1){1'b0}}, a_out_en}, {{(W-1){1'b0}}, ~oe_ba_n});
    @(posedge clk);
    if (!rst_n) begin
      m_hold_a = '0; m_hold_b = '0; m_st_ab = '0; m_st_ba = '0;
      m_cp_ab = 1'b0; m_cp_ba = 1'b0;
    end else begin
      if (le_ab || (m_cp_ab && !cp_ab)) m_st_ab = ea;
      if (le_ba || (m_cp_ba && !cp_ba)) m_st_ba = eb;
      m_hold_a = ea; m_hold_b = eb;
      m_cp_ab = cp_ab; m_cp_ba = cp_ba;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [W-1:0] v1, v2;
    void'($urandom(32'd4242));
    m_hold_a = '0; m_hold_b = '0; m_st_ab = '0; m_st_ba = '0;
    m_cp_ab = 1'b0; m_cp_ba = 1'b0;
    rst_n = 1'b0; a_in = 18'h2A5A5; b_in = 18'h15A5A; a_drv = '1; b_drv = '1;
    le_ab = 0; cp_ab = 0; oe_ab = 0; le_ba = 0; cp_ba = 0; oe_ba_n = 1;
    @(negedge clk);
    cycle("R1"); cycle("R1");
    rst_n = 1'b1;
    cycle("R1");

    // R2: transparent A to B, enable high (R7)
    v1 = 18'h3C0F1; a_in = v1; le_ab = 1; oe_ab = 1;
    cycle("R2");
    // R5: drop mode, change input: output retains v1
    le_ab = 0; a_in = 18'h00FFF;
    cycle("R5"); cycle("R5");
    // R6: rising capture clock loads nothing
    cp_ab = 1; a_in = 18'h12345;
    cycle("R6");
    // R3: falling edge cycle itself still shows old value
    cp_ab = 0;
    cycle("R3");
    // R4: new word visible next cycle
    a_in = 18'h0BEEF;
    cycle("R4"); cycle("R3");
    // R6: falling clock while transparent adds nothing
    le_ab = 1; cp_ab = 1; a_in = 18'h11111;
    cycle("R6");
    cp_ab = 0; a_in = 18'h22222;
    cycle("R6");
    le_ab = 0; a_in = 18'h33333;
    cycle("R6");
    // R7/R8 enable polarities, R11 data visible when disabled
    oe_ab = 0; oe_ba_n = 0;
    cycle("R7"); cycle("R11");
    oe_ab = 1; oe_ba_n = 1;
    cycle("R8");
    // R9: B to A transparent, retain, capture
    v2 = 18'h1D2E3; b_in = v2; le_ba = 1; oe_ba_n = 0;
    cycle("R9");
    le_ba = 0; b_in = 18'h00001;
    cycle("R9"); cp_ba = 1; cycle("R9"); cp_ba = 0; cycle("R9"); cycle("R9");
    // R10: keeper holds last driven word while undriven
    le_ab = 1; a_drv = '1; a_in = 18'h2F0F0;
    cycle("R10");
    a_drv = '0; a_in = 18'h10F0F;
    cycle("R10"); cycle("R10");
    a_drv = 18'h000FF; a_in = 18'h3FFFF;
    cycle("R10");
    a_drv = '1;
    cycle("R10");

    // Constrained random mix
    for (int i = 0; i < RAND_CYC; i++) begin
      a_in    = W'($urandom);
      b_in    = W'($urandom);
      a_drv   = ($urandom_range(0, 4) == 0) ? W'($urandom) : '1;
      b_drv   = ($urandom_range(0, 4) == 0) ? W'($urandom) : '1;
      le_ab   = ($urandom_range(0, 3) == 0);
      le_ba   = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 1) == 0) cp_ab = ~cp_ab;
      if ($urandom_range(0, 1) == 0) cp_ba = ~cp_ba;
      oe_ab   = $urandom_range(0, 1) == 1;
      oe_ba_n = $urandom_range(0, 1) == 1;
      cycle(le_ab ? "R2/R9" : "R3/R4/R9");
    end
    summary();
  end

endmodule